// File: doc/BRIEF.md
# Truth-Table Driven Pin Sequencer

This block is a small programmable sequencer that sits beside one pin of a larger chip. Two input pins, A and B, are synchronised and kept as a current and a previous sample each. Those four bits address a 16-entry truth table written by the host. The addressed table bit does not drive a level; it picks one of two five-bit commands. The picked command runs one operation on a 32-bit accumulator, may ask for a state change, and may copy the result into a snapshot register that the host reads.

A single state bit exists. In two-pattern mode it chooses which of two pattern registers, each with its own table and command pair, is in force. State changes are rate-divided: a programmable count N (1 to 32) of change requests must arrive before the bit toggles. The A slot of the table can be fed from the pin, from the state bit or from a chosen accumulator bit. The state bit can be driven onto an output pin. With a clock on B, a rising-edge table and a request command, the block produces a divided clock with no host involvement after setup.

Top module: `lut_pin_seq`

## Requirements
- R1: After reset the accumulator, snapshot, state bit, counter and all configuration registers are zero, so `pin_o` and `snap_o` read 0.
- R2: Each input passes through two synchronising flops and then a current and a previous sample flop. The table index is {B previous, B current, A previous, A current} (bit 3 down to bit 0). Table bit [index] set selects command 1, clear selects command 0. Pattern word layout: table in bits 15..0, command 0 in bits 20..16, command 1 in bits 25..21.
- R3: Command bits 2..0 pick the accumulator operation: 0 no change, 1 add one, 2 subtract one, 3 shift left (zero in), 4 shift right (zero in), 5 load 0, 6 load 1, 7 load all ones. One command executes per clock.
- R4: Command bit 3 is a state-change request. The state bit toggles on the N-th request, where N is the mode count field (bits 5..1) plus one; the counter reloads on each toggle.
- R5: Mode bit 0 set enables two-pattern mode: state 0 uses pattern register 0 and state 1 uses pattern register 1. With bit 0 clear pattern register 0 is always used.
- R6: Mode bits 7..6 choose the A slot source: 0 pin A, 1 the state bit, 2 or 3 the accumulator bit indexed by mode bits 12..8.
- R7: Command bit 4 loads the snapshot with the accumulator value the command produces; without it the snapshot holds.
- R8: A write to select 0 (mode), 1 (pattern 0) or 2 (pattern 1) clears the accumulator and state, reloads the counter from the (new) count field, and no command executes in that cycle; select 3 writes nothing. The snapshot is not cleared.
- R9: `pin_o` equals the state bit when mode bit 13 is set, else 0.
- R10: With a B clock of period P cycles, a rising-B table and a request command, `pin_o` has period 2·N·P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 pattern 0, 2 pattern 1 |
| cfg_wdata | input | 26 | Configuration write data |
| in_a | input | 1 | Input pin A (asynchronous) |
| in_b | input | 1 | Input pin B (asynchronous) |
| pin_o | output | 1 | State bit driven to the pin when enabled |
| snap_o | output | 32 | Snapshot of the accumulator |

## Verification
The bench builds the block with its defaults: a 32-bit accumulator, a 5-bit counter and two synchroniser stages. The 5-bit counter makes both ends of the division range, N=1 and N=32, reachable in a few hundred cycles, and the 32-bit accumulator lets decrement-from-zero and shift-to-carry-out wrap cases appear directly in the snapshot. Up/down counting in two-pattern mode and accumulator-bit feedback are compared each clock with a behavioural model.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int TBL_W  = 16;
    localparam int SEL_W  = 4;
    localparam int CMD_W  = 5;
    localparam int PAT_W  = TBL_W + 2 * CMD_W;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_INC  = 3'd1,
        OP_DEC  = 3'd2,
        OP_SHL  = 3'd3,
        OP_SHR  = 3'd4,
        OP_LD0  = 3'd5,
        OP_LD1  = 3'd6,
        OP_LDM1 = 3'd7
    } op_e;

    typedef struct packed {
        logic sig;
        logic req;
        op_e  op;
    } cmd_t;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_PAT0 = 2'd1,
        SEL_PAT1 = 2'd2,
        SEL_NONE = 2'd3
    } csel_e;

    typedef enum logic [1:0] {
        SRC_PIN   = 2'd0,
        SRC_STATE = 2'd1,
        SRC_ACC   = 2'd2,
        SRC_ACC_B = 2'd3
    } asrc_e;
endpackage

// File: rtl/pls_sync.sv
module pls_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pls_alu.sv
module pls_alu
    import pls_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        unique case (op)
            OP_NOP:  y = a;
            OP_INC:  y = a + ONE;
            OP_DEC:  y = a - ONE;
            OP_SHL:  y = {a[W-2:0], 1'b0};
            OP_SHR:  y = {1'b0, a[W-1:1]};
            OP_LD0:  y = '0;
            OP_LD1:  y = ONE;
            OP_LDM1: y = '1;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/pls_decode.sv
module pls_decode
    import pls_pkg::*;
(
    input  logic [PAT_W-1:0] pat,
    input  logic [SEL_W-1:0] idx,
    output cmd_t             cmd
);
    logic [TBL_W-1:0] tbl;
    logic             hit;
    cmd_t             cmd_lo;
    cmd_t             cmd_hi;

    always_comb begin
        tbl    = pat[TBL_W-1:0];
        hit    = tbl[idx];
        cmd_lo = cmd_t'(pat[TBL_W +: CMD_W]);
        cmd_hi = cmd_t'(pat[TBL_W + CMD_W +: CMD_W]);
        cmd    = hit ? cmd_hi : cmd_lo;
    end
endmodule

// File: rtl/lut_pin_seq.sv
module lut_pin_seq
    import pls_pkg::*;
#(
    parameter int ACC_W       = 32,
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [PAT_W-1:0] cfg_wdata,
    input  logic             in_a,
    input  logic             in_b,
    output logic             pin_o,
    output logic [ACC_W-1:0] snap_o
);
    localparam int IDX_W    = $clog2(ACC_W);
    localparam int M_TWO    = 0;
    localparam int M_CNT_LO = 1;
    localparam int M_SRC_LO = M_CNT_LO + CNT_W;
    localparam int M_IDX_LO = M_SRC_LO + 2;
    localparam int M_OEN    = M_IDX_LO + IDX_W;
    localparam int MODE_W   = M_OEN + 1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [PAT_W-1:0]  pat0;
        logic [PAT_W-1:0]  pat1;
        logic              a_prev;
        logic              a_cur;
        logic              b_prev;
        logic              b_cur;
        logic [ACC_W-1:0]  acc;
        logic [ACC_W-1:0]  snap;
        logic              state;
        logic [CNT_W-1:0]  cnt;
    } regs_t;

    regs_t r_q, r_d;

    logic [1:0]       pin_raw;
    logic [1:0]       pin_sync;
    logic             two_pat;
    logic [CNT_W-1:0] count_m1;
    asrc_e            a_src;
    logic [IDX_W-1:0] fb_idx;
    logic             out_en;
    logic             a_src_val;
    logic [PAT_W-1:0] pat_act;
    logic [SEL_W-1:0] tbl_idx;
    cmd_t             cur_cmd;
    logic [ACC_W-1:0] alu_y;
    logic             wr_hit;

    assign pin_raw = {in_b, in_a};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        pls_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (pin_raw[g]),
            .q    (pin_sync[g])
        );
    end

    always_comb begin
        two_pat  = r_q.mode[M_TWO];
        count_m1 = r_q.mode[M_CNT_LO +: CNT_W];
        a_src    = asrc_e'(r_q.mode[M_SRC_LO +: 2]);
        fb_idx   = r_q.mode[M_IDX_LO +: IDX_W];
        out_en   = r_q.mode[M_OEN];
        case (a_src)
            SRC_PIN:   a_src_val = pin_sync[0];
            SRC_STATE: a_src_val = r_q.state;
            default:   a_src_val = r_q.acc[fb_idx];
        endcase
        pat_act = (two_pat && r_q.state) ? r_q.pat1 : r_q.pat0;
        tbl_idx = {r_q.b_prev, r_q.b_cur, r_q.a_prev, r_q.a_cur};
        wr_hit  = cfg_we && (csel_e'(cfg_sel) != SEL_NONE);
    end

    pls_decode u_decode (
        .pat(pat_act),
        .idx(tbl_idx),
        .cmd(cur_cmd)
    );

    pls_alu #(.W(ACC_W)) u_alu (
        .op(cur_cmd.op),
        .a (r_q.acc),
        .y (alu_y)
    );

    always_comb begin
        r_d        = r_q;
        r_d.a_prev = r_q.a_cur;
        r_d.a_cur  = a_src_val;
        r_d.b_prev = r_q.b_cur;
        r_d.b_cur  = pin_sync[1];
        if (wr_hit) begin
            unique case (csel_e'(cfg_sel))
                SEL_MODE: r_d.mode = cfg_wdata[MODE_W-1:0];
                SEL_PAT0: r_d.pat0 = cfg_wdata;
                SEL_PAT1: r_d.pat1 = cfg_wdata;
                default:  r_d.mode = r_q.mode;
            endcase
            r_d.acc   = '0;
            r_d.state = 1'b0;
            r_d.cnt   = r_d.mode[M_CNT_LO +: CNT_W];
        end else begin
            r_d.acc = alu_y;
            if (cur_cmd.req) begin
                if (r_q.cnt == '0) begin
                    r_d.state = ~r_q.state;
                    r_d.cnt   = count_m1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_ONE;
                end
            end
            if (cur_cmd.sig) r_d.snap = alu_y;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pin_o  = out_en & r_q.state;
    assign snap_o = r_q.snap;
endmodule

// File: rtl/pls_checker.sv
module pls_checker #(
    parameter int ACC_W = 32,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_hit,
    input logic [4:0]       cmd_bits,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] count_m1,
    input logic             state,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] snap,
    input logic             pin
);
    localparam logic [ACC_W-1:0] ONE = {{(ACC_W-1){1'b0}}, 1'b1};

    assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !cmd_bits[4]) |=> $stable(snap));

    assert_cfg_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (acc == '0 && !state));

    assert_state_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !(cmd_bits[3] && cnt == '0)) |=> $stable(state));

    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= count_m1);

    assert_inc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && cmd_bits[2:0] == 3'd1) |=> acc == $past(acc) + ONE);

    assert_pin_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pin |-> state);
endmodule

bind lut_pin_seq pls_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_hit),
    .cmd_bits(cur_cmd),
    .cnt     (r_q.cnt),
    .count_m1(count_m1),
    .state   (r_q.state),
    .acc     (r_q.acc),
    .snap    (snap_o),
    .pin     (pin_o)
);

// File: tb/lut_pin_seq_tb.sv
module lut_pin_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [25:0] cfg_wdata = '0;
    logic        in_a = 1'b0;
    logic        in_b = 1'b0;
    logic        pin_o;
    logic [31:0] snap_o;

    int    n_chk = 0;
    int    n_err = 0;
    bit    fin = 1'b0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    lut_pin_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .in_a(in_a), .in_b(in_b),
        .pin_o(pin_o), .snap_o(snap_o)
    );

    // command bits
    localparam logic [4:0] SIG = 5'b10000;
    localparam logic [4:0] REQ = 5'b01000;

    function automatic logic [25:0] mk_pat(input logic [15:0] tbl, input logic [4:0] c0, input logic [4:0] c1);
        return {c1, c0, tbl};
    endfunction

    function automatic logic [25:0] mk_mode(input bit two, input int n, input logic [1:0] src,
                                            input logic [4:0] idx, input bit oen);
        logic [4:0] nm1;
        nm1 = 5'(n - 1);
        return {12'd0, oen, idx, src, nm1, two};
    endfunction

    function automatic logic [31:0] alu_ref(input logic [2:0] op, input logic [31:0] a);
        case (op)
            3'd1: return a + 32'd1;
            3'd2: return a - 32'd1;
            3'd3: return a << 1;
            3'd4: return a >> 1;
            3'd5: return 32'd0;
            3'd6: return 32'd1;
            3'd7: return 32'hFFFF_FFFF;
            default: return a;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_mode, m_acc, m_snap;
    logic [25:0] m_p0, m_p1;
    logic        m_s1a, m_s2a, m_s1b, m_s2b, m_ac, m_ap, m_bc, m_bp, m_st;
    int          m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = '0; m_acc = '0; m_snap = '0; m_p0 = '0; m_p1 = '0;
            m_s1a = 0; m_s2a = 0; m_s1b = 0; m_s2b = 0;
            m_ac = 0; m_ap = 0; m_bc = 0; m_bp = 0; m_st = 0; m_cnt = 0;
        end else begin
            logic        src;
            logic [3:0]  idx;
            logic [25:0] pat;
            logic [4:0]  cmd;
            logic [31:0] res;
            case (m_mode[7:6])
                2'd0:    src = m_s2a;
                2'd1:    src = m_st;
                default: src = m_acc[m_mode[12:8]];
            endcase
            idx = {m_bp, m_bc, m_ap, m_ac};
            pat = (m_mode[0] && m_st) ? m_p1 : m_p0;
            cmd = pat[idx] ? pat[25:21] : pat[20:16];
            res = alu_ref(cmd[2:0], m_acc);
            m_ap = m_ac; m_ac = src; m_bp = m_bc; m_bc = m_s2b;
            m_s2a = m_s1a; m_s1a = in_a; m_s2b = m_s1b; m_s1b = in_b;
            if (cfg_we && cfg_sel != 2'd3) begin
                case (cfg_sel)
                    2'd0: m_mode = {6'd0, cfg_wdata};
                    2'd1: m_p0 = cfg_wdata;
                    default: m_p1 = cfg_wdata;
                endcase
                m_acc = '0; m_st = 0; m_cnt = int'(m_mode[5:1]);
            end else begin
                m_acc = res;
                if (cmd[3]) begin
                    if (m_cnt == 0) begin m_st = !m_st; m_cnt = int'(m_mode[5:1]); end
                    else m_cnt--;
                end
                if (cmd[4]) m_snap = res;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(snap_o == m_snap, {cur_tag, " snapshot vs model"}, snap_o, m_snap);
            chk(pin_o == (m_mode[13] & m_st), {cur_tag, " pin vs model"}, 32'(pin_o), 32'(m_mode[13] & m_st));
        end
    end

    // background B clock, half period bhalf cycles
    bit bgen = 1'b0;
    int bhalf = 2;
    int bcnt = 0;
    always @(negedge clk) begin
        if (bgen) begin
            bcnt++;
            if (bcnt >= bhalf) begin bcnt = 0; in_b <= ~in_b; end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [25:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input bit on_b, input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) begin
            if (on_b) in_b = 1'b1; else in_a = 1'b1;
            repeat (hi) @(negedge clk);
            if (on_b) in_b = 1'b0; else in_a = 1'b0;
            repeat (lo) @(negedge clk);
        end
    endtask

    task automatic pin_period(output int cyc);
        logic p;
        p = pin_o;
        forever begin @(negedge clk); if (pin_o && !p) break; p = pin_o; end
        cyc = 0; p = pin_o;
        forever begin @(negedge clk); cyc++; if (pin_o && !p) break; p = pin_o; end
    endtask

    task automatic summary;
        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired (any requirement) actual=hung expected=done");
        summary();
    end

    initial begin
        int per;
        bit quiet;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(snap_o == 0, "R1 snapshot after reset", snap_o, 0);
        chk(pin_o == 0, "R1 pin after reset", 32'(pin_o), 0);

        // R3 operations, table always picks command 1
        cur_tag = "R3";
        cfg_write(2'd0, mk_mode(0, 1, 2'd0, 5'd0, 0));
        cfg_write(2'd1, mk_pat(16'hFFFF, 5'd0, SIG | 5'd6));
        @(negedge clk); chk(snap_o == 32'd1, "R3 load one", snap_o, 1);
        cfg_write(2'd1, mk_pat(16'hFFFF, 5'd0, SIG | 5'd7));
        @(negedge clk); chk(snap_o == 32'hFFFF_FFFF, "R3 load all ones", snap_o, 32'hFFFF_FFFF);
        cfg_write(2'd1, mk_pat(16'hFFFF, 5'd0, SIG | 5'd2));
        @(negedge clk); chk(snap_o == 32'hFFFF_FFFF, "R3 decrement from zero", snap_o, 32'hFFFF_FFFF);
        @(negedge clk); chk(snap_o == 32'hFFFF_FFFE, "R3 second decrement", snap_o, 32'hFFFF_FFFE);
        cfg_write(2'd1, mk_pat(16'hFFFF, 5'd0, SIG | 5'd5));
        @(negedge clk); chk(snap_o == 32'd0, "R3 load zero", snap_o, 0);
        // R8 write clears accumulator: increment restarts from zero
        cfg_write(2'd1, mk_pat(16'hFFFF, 5'd0, SIG | 5'd1));
        repeat (5) @(negedge clk);
        cfg_write(2'd3, mk_pat(16'h0000, 5'd0, 5'd0));
        @(negedge clk); chk(snap_o == 32'd7, "R8 select 3 writes nothing", snap_o, 7);
        cur_tag = "R8";
        cfg_write(2'd1, mk_pat(16'hFFFF, 5'd0, SIG | 5'd1));
        @(negedge clk); chk(snap_o == 32'd1, "R8 accumulator cleared by write", snap_o, 1);
        // shifts: load on B rise, shift otherwise
        cur_tag = "R3";
        cfg_write(2'd1, mk_pat(16'h00F0, SIG | 5'd3, SIG | 5'd6));
        pulse(1, 1, 2, 12);
        cfg_write(2'd1, mk_pat(16'h00F0, SIG | 5'd4, SIG | 5'd7));
        pulse(1, 1, 2, 12);

        // R2 edge detection on B and A
        cur_tag = "R2";
        cfg_write(2'd1, mk_pat(16'h00F0, 5'd0, SIG | 5'd1));
        pulse(1, 5, 3, 3); repeat (6) @(negedge clk);
        chk(snap_o == 32'd5, "R2 rising B edges counted", snap_o, 5);
        cfg_write(2'd1, mk_pat(16'h0F00, 5'd0, SIG | 5'd1));
        pulse(1, 6, 2, 4); repeat (6) @(negedge clk);
        chk(snap_o == 32'd6, "R2 falling B edges counted", snap_o, 6);
        cfg_write(2'd1, mk_pat(16'h2222, 5'd0, SIG | 5'd1));
        pulse(0, 4, 2, 3); repeat (6) @(negedge clk);
        chk(snap_o == 32'd4, "R2 rising A edges counted", snap_o, 4);

        // R7 no signal flag: snapshot holds
        cur_tag = "R7";
        cfg_write(2'd1, mk_pat(16'h2222, 5'd0, 5'd1));
        pulse(0, 3, 2, 3); repeat (6) @(negedge clk);
        chk(snap_o == 32'd4, "R7 snapshot held without signal", snap_o, 4);

        // R5 up/down counting, N=3
        cur_tag = "R5";
        cfg_write(2'd1, mk_pat(16'hFFFF, 5'd0, SIG | REQ | 5'd1));
        cfg_write(2'd2, mk_pat(16'hFFFF, 5'd0, SIG | REQ | 5'd2));
        cfg_write(2'd0, mk_mode(1, 3, 2'd0, 5'd0, 1));
        for (int i = 1; i <= 13; i++) begin
            int k;
            @(negedge clk);
            k = i % 6;
            chk(snap_o == 32'((k <= 3) ? k : 6 - k), "R5 up/down triangle", snap_o, 32'((k <= 3) ? k : 6 - k));
        end

        // R6 feedback of accumulator bit 3 into A slot
        cur_tag = "R6";
        cfg_write(2'd1, mk_pat(16'hAAAA, SIG | 5'd1, SIG | 5'd0));
        cfg_write(2'd0, mk_mode(0, 1, 2'd2, 5'd3, 0));
        repeat (20) @(negedge clk);
        chk(snap_o == 32'd9, "R6 accumulator bit feedback stops count", snap_o, 9);
        // state feedback
        cfg_write(2'd1, mk_pat(16'hAAAA, SIG | REQ | 5'd1, SIG | 5'd2));
        cfg_write(2'd0, mk_mode(0, 2, 2'd1, 5'd0, 1));
        repeat (30) @(negedge clk);

        // R10 / R4 divided clock
        cur_tag = "R10";
        cfg_write(2'd1, mk_pat(16'h00F0, 5'd0, REQ));
        cfg_write(2'd0, mk_mode(0, 4, 2'd0, 5'd0, 1));
        bhalf = 2; bcnt = 0; bgen = 1'b1;
        pin_period(per);
        chk(per == 32, "R10 divide by 4 period", 32'(per), 32);
        cur_tag = "R9";
        cfg_write(2'd0, mk_mode(0, 4, 2'd0, 5'd0, 0));
        quiet = 1'b1;
        repeat (100) begin @(negedge clk); if (pin_o) quiet = 1'b0; end
        chk(quiet, "R9 pin low when output disabled", 32'(!quiet), 0);
        cur_tag = "R4";
        cfg_write(2'd0, mk_mode(0, 1, 2'd0, 5'd0, 1));
        pin_period(per);
        chk(per == 8, "R4 divide by 1 period", 32'(per), 8);
        bgen = 1'b0; @(negedge clk); bhalf = 1; bcnt = 0; bgen = 1'b1;
        cfg_write(2'd0, mk_mode(0, 32, 2'd0, 5'd0, 1));
        pin_period(per);
        chk(per == 128, "R4 divide by 32 period", 32'(per), 128);
        bgen = 1'b0; @(negedge clk); in_b = 1'b0;
        repeat (10) @(negedge clk);
        summary();
    end
endmodule